// File: doc/BRIEF.md
# Symbolic Store-Window Disambiguation Checker

This block sits just after the register-tracking stage of an out-of-order core and tells the scheduler, for each load, whether that load can be issued ahead of every older store still in flight. It keeps a small program-ordered window of stores. Each entry holds the symbolic address that the tracker produced: a base register index, an accumulated signed offset, an access size, a flag that says whether the tracker could follow the base register, and optionally a fully resolved effective address.

A load is proven independent of a store in one of two ways. If both carry resolved addresses, their byte ranges are compared directly. Otherwise, if both are trackable and name the same base register, their offset ranges are compared. A pair that fits neither case is treated as a possible conflict. No speculation is involved, so nothing ever has to be undone. Stores join the window at the tail and leave from the head when the back-end signals retirement. When a register is written again, every stored entry that uses it as a base stops being trackable.

Top module: `disamb_checker`

## Requirements
- R1: After reset the window is empty, `st_full` is 0 and `ld_resp_valid` is 0. A load presented while the window is empty is reported independent.
- R2: Every load on `ld_valid` produces exactly one `ld_resp_valid` pulse in the next cycle, carrying the verdict on `ld_indep`. `ld_resp_valid` never rises without a load in the previous cycle.
- R3: When a load and a stored entry are both trackable (flag 1), share the base index and lack resolved addresses on at least one side, the load is independent of that store if their signed offset byte ranges do not overlap. Negative offsets are compared as two's complement.
- R4: Access size code 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes. A range covers the bytes from offset to offset plus size minus one. Any shared byte makes the pair a conflict.
- R5: If either side is untrackable, or the base indices differ, and resolved addresses are not available on both sides, the pair is a conflict.
- R6: When both the load and the store carry resolved addresses (valid flag 1), the verdict comes from comparing address byte ranges. Base indices and tracking flags are ignored in that case.
- R7: A redefinition pulse for register index k clears the tracking flag of every entry already in the window whose base is k. A store entering in the same cycle as the redefinition keeps its own flag.
- R8: The window holds 8 stores. `st_full` is 1 exactly when 8 are held, and a store presented while full is dropped.
- R9: A retire pulse removes the oldest store. A retire pulse on an empty window has no effect. A retire and an insert in the same cycle both take effect.
- R10: A load is compared against the stores held at the start of its cycle. A store inserted in the same cycle is treated as younger. A store retired in the same cycle still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Insert a store at the window tail |
| st_base | input | 5 | Store base register index |
| st_off | input | 16 | Store signed accumulated offset |
| st_track | input | 1 | Store base is trackable |
| st_size | input | 2 | Store size code |
| st_addr_ok | input | 1 | Store resolved address is valid |
| st_addr | input | 32 | Store resolved address |
| ld_valid | input | 1 | Load query |
| ld_base | input | 5 | Load base register index |
| ld_off | input | 16 | Load signed accumulated offset |
| ld_track | input | 1 | Load base is trackable |
| ld_size | input | 2 | Load size code |
| ld_addr_ok | input | 1 | Load resolved address is valid |
| ld_addr | input | 32 | Load resolved address |
| retire | input | 1 | Oldest store has retired |
| redef_valid | input | 1 | A register has been redefined |
| redef_reg | input | 5 | Index of the redefined register |
| st_full | output | 1 | Window holds 8 stores |
| ld_resp_valid | output | 1 | Verdict for the load of the previous cycle |
| ld_indep | output | 1 | Load may bypass all older stores |

## Verification
The hardest situations to reach are those where several events land in one cycle: a retire together with an insert while the window is nearly full, a redefinition together with a store that uses the same base, and a load together with an insert or a retire. The stimulus walks the window through a complete wrap. It places these coincident events at known occupancies and then uses follow-up loads with chosen offsets or addresses to reveal which stores are present and whether each one is still trackable.

// File: rtl/disamb_pkg.sv
// Shared widths and the symbolic memory reference record.
package disamb_pkg;
    parameter int REG_W  = 5;
    parameter int OFF_W  = 16;
    parameter int ADDR_W = 32;
    parameter int SZ_W   = 2;

    typedef struct packed {
        logic [REG_W-1:0]  base;
        logic [OFF_W-1:0]  off;     // two's complement
        logic              track;
        logic [SZ_W-1:0]   size;    // bytes = 1 << size
        logic              addr_ok;
        logic [ADDR_W-1:0] addr;
    } mem_ref_t;
endpackage

// File: rtl/disamb_pair_cmp.sv
// Decides whether one stored reference may overlap one load.
// Assumes: resolved addresses take priority; otherwise same trackable
// base with disjoint offset ranges proves independence.
module disamb_pair_cmp
    import disamb_pkg::*;
(
    input  mem_ref_t st_ref,
    input  mem_ref_t ld_ref,
    output logic     conflict
);
    localparam int OW = OFF_W + 2;
    localparam int AW = ADDR_W + 1;
    localparam int BW = (1 << SZ_W) + 1;

    logic [BW-1:0]        st_bytes, ld_bytes;
    logic signed [OW-1:0] s_lo, s_hi, l_lo, l_hi;
    logic [AW-1:0]        sa_lo, sa_hi, la_lo, la_hi;
    logic                 off_disjoint, addr_disjoint;

    // Build byte ranges for both offsets and addresses.
    always_comb begin
        st_bytes = BW'(1) << st_ref.size;
        ld_bytes = BW'(1) << ld_ref.size;
        s_lo  = $signed({{2{st_ref.off[OFF_W-1]}}, st_ref.off});
        l_lo  = $signed({{2{ld_ref.off[OFF_W-1]}}, ld_ref.off});
        s_hi  = s_lo + $signed({{(OW-BW){1'b0}}, st_bytes});
        l_hi  = l_lo + $signed({{(OW-BW){1'b0}}, ld_bytes});
        sa_lo = {1'b0, st_ref.addr};
        la_lo = {1'b0, ld_ref.addr};
        sa_hi = sa_lo + {{(AW-BW){1'b0}}, st_bytes};
        la_hi = la_lo + {{(AW-BW){1'b0}}, ld_bytes};
        off_disjoint  = (s_hi <= l_lo) || (l_hi <= s_lo);
        addr_disjoint = (sa_hi <= la_lo) || (la_hi <= sa_lo);
    end

    // Pick the proof that applies; anything unproven is a conflict.
    always_comb begin
        if (st_ref.addr_ok && ld_ref.addr_ok)
            conflict = !addr_disjoint;
        else if (st_ref.track && ld_ref.track && (st_ref.base == ld_ref.base))
            conflict = !off_disjoint;
        else
            conflict = 1'b1;
    end
endmodule

// File: rtl/disamb_store_window.sv
// Program-ordered circular store window.
// Assumes: insert only when not full; retire removes the head;
// redefinition clears tracking of held entries with a matching base.
module disamb_store_window
    import disamb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  mem_ref_t         ins_ref,
    input  logic             retire,
    input  logic             redef_valid,
    input  logic [REG_W-1:0] redef_reg,
    output mem_ref_t         entries [DEPTH],
    output logic [DEPTH-1:0] slot_valid,
    output logic [CNT_W-1:0] occ,
    output logic             full
);
    logic [PTR_W-1:0] head, tail;
    logic             do_ins, do_ret;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy.
    always_comb begin
        full   = (occ == CNT_W'(DEPTH));
        do_ins = ins_valid && !full;
        do_ret = retire && (occ != '0);
    end

    // Update storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head       <= '0;
            tail       <= '0;
            occ        <= '0;
            slot_valid <= '0;
            for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (redef_valid && (entries[i].base == redef_reg))
                    entries[i].track <= 1'b0;
            if (do_ins) begin
                entries[tail]    <= ins_ref;
                slot_valid[tail] <= 1'b1;
                tail             <= ptr_next(tail);
            end
            if (do_ret) begin
                slot_valid[head] <= 1'b0;
                head             <= ptr_next(head);
            end
            if (do_ins && !do_ret)      occ <= occ + 1'b1;
            else if (do_ret && !do_ins) occ <= occ - 1'b1;
        end
    end
endmodule

// File: rtl/disamb_checker.sv
// Top: store window plus one comparator per slot; registers a verdict
// for every load one cycle after it is presented.
// Assumes: inputs arrive in program order, a load in the same cycle as a
// store is the older of the two.
module disamb_checker
    import disamb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [REG_W-1:0]  st_base,
    input  logic [OFF_W-1:0]  st_off,
    input  logic              st_track,
    input  logic [SZ_W-1:0]   st_size,
    input  logic              st_addr_ok,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_base,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic              ld_track,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              ld_addr_ok,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              retire,
    input  logic              redef_valid,
    input  logic [REG_W-1:0]  redef_reg,
    output logic              st_full,
    output logic              ld_resp_valid,
    output logic              ld_indep
);
    mem_ref_t         st_ref, ld_ref;
    mem_ref_t         entries [DEPTH];
    logic [DEPTH-1:0] slot_valid, hit;
    logic [CNT_W-1:0] occ;
    logic             indep_now;

    // Pack port fields into reference records.
    always_comb begin
        st_ref = '{base: st_base, off: st_off, track: st_track,
                   size: st_size, addr_ok: st_addr_ok, addr: st_addr};
        ld_ref = '{base: ld_base, off: ld_off, track: ld_track,
                   size: ld_size, addr_ok: ld_addr_ok, addr: ld_addr};
    end

    disamb_store_window #(.DEPTH(DEPTH)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (st_valid),
        .ins_ref    (st_ref),
        .retire     (retire),
        .redef_valid(redef_valid),
        .redef_reg  (redef_reg),
        .entries    (entries),
        .slot_valid (slot_valid),
        .occ        (occ),
        .full       (st_full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        disamb_pair_cmp u_cmp (
            .st_ref  (entries[g]),
            .ld_ref  (ld_ref),
            .conflict(hit[g])
        );
    end

    // Independent only if no held store may overlap.
    always_comb indep_now = ~|(hit & slot_valid);

    // Register the verdict for the scheduler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_resp_valid <= 1'b0;
            ld_indep      <= 1'b0;
        end else begin
            ld_resp_valid <= ld_valid;
            ld_indep      <= ld_valid && indep_now;
        end
    end
endmodule

// File: rtl/disamb_checker_sva.sv
// Protocol and occupancy properties for disamb_checker, bound below.
module disamb_checker_sva #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             retire,
    input logic             ld_valid,
    input logic             st_full,
    input logic             ld_resp_valid,
    input logic             ld_indep,
    input logic [CNT_W-1:0] occ
);
    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_resp_valid);
    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_resp_valid);
    assert_empty_indep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && ld_valid) |=> ld_indep);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && st_valid && !retire) |=> st_full);
    assert_retire_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && retire && !st_valid) |=> occ == '0);
    assert_insert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_full && !retire) |=> occ == CNT_W'($past(occ) + 1'b1));
endmodule

bind disamb_checker disamb_checker_sva #(.DEPTH(DEPTH)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .retire       (retire),
    .ld_valid     (ld_valid),
    .st_full      (st_full),
    .ld_resp_valid(ld_resp_valid),
    .ld_indep     (ld_indep),
    .occ          (occ)
);

// File: tb/test_disamb_checker.sv
module test_disamb_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, st_track = 0, st_addr_ok = 0;
    logic [4:0]  st_base = '0;
    logic [15:0] st_off = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_addr = '0;
    logic        ld_valid = 0, ld_track = 0, ld_addr_ok = 0;
    logic [4:0]  ld_base = '0;
    logic [15:0] ld_off = '0;
    logic [1:0]  ld_size = '0;
    logic [31:0] ld_addr = '0;
    logic        retire = 0, redef_valid = 0;
    logic [4:0]  redef_reg = '0;
    logic        st_full, ld_resp_valid, ld_indep;

    int checks = 0, errors = 0;
    bit done = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    disamb_checker i_disamb_checker (.*);

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected verdict per response.
    always @(negedge clk) begin
        if (rst_n && ld_resp_valid) begin
            if (exp_q.size() == 0) check_bit(ld_resp_valid, 1'b0, "R2 unexpected response");
            else begin
                check_bit(ld_indep, exp_q[0], tag_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic set_store(input logic [4:0] b, input logic [15:0] o, input logic t,
                             input logic [1:0] s, input logic ao, input logic [31:0] a);
        st_valid = 1; st_base = b; st_off = o; st_track = t;
        st_size = s; st_addr_ok = ao; st_addr = a;
    endtask

    task automatic set_load(input logic [4:0] b, input logic [15:0] o, input logic t,
                            input logic [1:0] s, input logic ao, input logic [31:0] a,
                            input bit exp, input string tag);
        ld_valid = 1; ld_base = b; ld_off = o; ld_track = t;
        ld_size = s; ld_addr_ok = ao; ld_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic tick();
        @(negedge clk);
        st_valid = 0; ld_valid = 0; retire = 0; redef_valid = 0;
    endtask

    task automatic do_retire();
        retire = 1; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_bit(st_full, 1'b0, "R1 full after reset");
        check_bit(ld_resp_valid, 1'b0, "R1 no response after reset");

        set_load(5'd3, 16'd0, 1, 2'd2, 0, 0, 1, "R1 empty window"); tick();

        // Store A: base 1, offset 0, 4 bytes, trackable
        set_store(5'd1, 16'd0, 1, 2'd2, 0, 0); tick();
        set_load(5'd1, 16'd4, 1, 2'd0, 0, 0, 1, "R3 disjoint above"); tick();
        set_load(5'd1, 16'd2, 1, 2'd0, 0, 0, 0, "R4 inside store range"); tick();
        set_load(5'd1, 16'hFFFC, 1, 2'd2, 0, 0, 1, "R3 negative disjoint"); tick();
        set_load(5'd1, 16'hFFFE, 1, 2'd2, 0, 0, 0, "R4 straddling load"); tick();
        set_load(5'd1, 16'd3, 1, 2'd3, 0, 0, 0, "R4 eight byte load"); tick();
        set_load(5'd1, 16'd0, 0, 2'd0, 0, 0, 0, "R5 untrackable load"); tick();
        set_load(5'd2, 16'd100, 1, 2'd0, 0, 0, 0, "R5 different base"); tick();

        // Store B: resolved 0x200, 4 bytes, base 5 untrackable
        set_store(5'd5, 16'd0, 0, 2'd2, 1, 32'h200); tick();
        set_load(5'd1, 16'd4, 1, 2'd0, 1, 32'h204, 1, "R6 resolved disjoint"); tick();
        set_load(5'd1, 16'd8, 1, 2'd0, 1, 32'h203, 0, "R6 resolved overlap"); tick();

        do_retire(); do_retire(); do_retire();
        set_store(5'd4, 16'd0, 1, 2'd2, 0, 0); tick();
        set_load(5'd4, 16'd0, 1, 2'd0, 0, 0, 0, "R9 retire on empty ignored"); tick();
        do_retire();
        set_load(5'd4, 16'd0, 1, 2'd0, 0, 0, 1, "R9 store retired"); tick();

        // Store D: base 6, offset 0, 1 byte; then base 6 redefined
        set_store(5'd6, 16'd0, 1, 2'd0, 0, 0); tick();
        redef_valid = 1; redef_reg = 5'd6; tick();
        set_load(5'd6, 16'd8, 1, 2'd0, 0, 0, 0, "R7 stale base"); tick();
        retire = 1; redef_valid = 1; redef_reg = 5'd6;
        set_store(5'd6, 16'd16, 1, 2'd0, 0, 0); tick();
        set_load(5'd6, 16'd0, 1, 2'd0, 0, 0, 1, "R7 same-cycle store keeps flag"); tick();
        redef_valid = 1; redef_reg = 5'd9; tick();
        set_load(5'd6, 16'd4, 1, 2'd0, 0, 0, 1, "R7 other register untouched"); tick();

        set_store(5'd6, 16'd0, 1, 2'd0, 0, 0);
        set_load(5'd6, 16'd0, 1, 2'd0, 0, 0, 1, "R10 same-cycle store younger"); tick();
        set_load(5'd6, 16'd0, 1, 2'd0, 0, 0, 0, "R10 store now held"); tick();
        retire = 1;
        set_load(5'd6, 16'd16, 1, 2'd0, 0, 0, 0, "R10 retiring store still counts"); tick();
        do_retire();

        for (int i = 0; i < 8; i++) begin
            set_store(5'd0, 16'd0, 0, 2'd2, 1, 32'h100 + 32'(16 * i)); tick();
        end
        check_bit(st_full, 1'b1, "R8 full at eight");
        set_store(5'd0, 16'd0, 0, 2'd2, 1, 32'h900); tick();
        set_load(5'd0, 16'd0, 0, 2'd2, 1, 32'h900, 1, "R8 store dropped when full"); tick();
        set_load(5'd0, 16'd0, 0, 2'd2, 1, 32'h170, 0, "R8 last store held"); tick();
        do_retire();
        check_bit(st_full, 1'b0, "R8 not full after retire");
        retire = 1;
        set_store(5'd0, 16'd0, 0, 2'd2, 1, 32'h900); tick();
        check_bit(st_full, 1'b0, "R9 retire with insert keeps seven");
        set_store(5'd0, 16'd0, 0, 2'd2, 1, 32'hA00); tick();
        check_bit(st_full, 1'b1, "R8 full again after wrap");
        set_load(5'd0, 16'd0, 0, 2'd0, 1, 32'h902, 0, "R9 inserted with retire"); tick();
        set_load(5'd0, 16'd0, 0, 2'd2, 1, 32'h110, 1, "R9 oldest removed"); tick();
        for (int i = 0; i < 8; i++) do_retire();
        check_bit(st_full, 1'b0, "R8 drained");
        set_load(5'd0, 16'd0, 0, 2'd2, 1, 32'hA00, 1, "R1 empty after drain"); tick();

        repeat (3) tick();
        check_bit(exp_q.size() == 0, 1'b1, "R2 every load answered");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule